// File: doc/BRIEF.md
# Configurable Serial Transceiver with Programmable Line Levels

This block is an asynchronous serial transmitter and receiver for a single byte of traffic in each direction. A free-running tick input paces it at sixteen times the bit rate. Software-facing configuration pins select eight or nine data bits, optional parity with odd or even sense, one or two stop bits, and the logic level used for the start bit and for the stop bit. The idle line rests at the stop level.

The ninth bit slot appears either when nine-bit frames are selected or when parity is on. When parity is on, that slot carries the computed parity; otherwise it carries a user-supplied data bit. The receiver samples each bit at its middle and discards a start bit that has gone away by mid-bit. It then reports the byte, the ninth bit, and the framing and parity status.

An optional request/clear handshake holds the transmitter back while the partner is not ready, and lowers the outgoing ready signal while a received byte waits to be read. A flush pulse abandons any transfer in progress on both sides and clears all status.

Top module: `uart_xcvr`

## Requirements
- R1: The frame sends a start bit at the start level, then the data bits LSB first, then the optional ninth slot, then the stop bits. Each bit lasts OSR (16) ticks. While the transmitter is idle, txd sits at the stop level.
- R2: The ninth slot is present when cfg_nine=1 or cfg_par_en=1. With parity off it carries tx_bit8, and the receiver returns the slot value on rx_bit8. Without the slot, rx_bit8 is 0.
- R3: With cfg_par_en=1 the slot holds parity over the data bits. When cfg_par_even=0, the count of ones in data plus parity is odd; when cfg_par_even=1, that count is even.
- R4: cfg_two_stop=0 sends one stop bit and cfg_two_stop=1 sends two. The receiver checks every stop bit it expects.
- R5: The levels are programmable. With cfg_start_lvl=1 and cfg_stop_lvl=0, frames are sent and received with those inverted levels. The two levels must differ.
- R6: tx_done sets when the last stop bit ends and clears when the next write is accepted. A tx_wr that arrives while the transmitter is active has no effect.
- R7: The receiver takes its start decision OSR/2 ticks after it first sees the start level. If the line is no longer at the start level by then, the start is rejected and no byte is stored. Every later bit is sampled OSR ticks after the previous one.
- R8: rx_full sets when a frame is received, and rx_data/rx_bit8 then hold its contents. rx_rd clears rx_full.
- R9: frame_err is set for each received frame that has a stop bit not at the stop level. par_err is set for each received frame whose parity slot disagrees with the data. Both flags are recomputed on every received frame.
- R10: With cfg_flow_en=1, a written byte waits while cts=0 and txd stays at the stop level; in the same mode, rts is 0 while rx_full=1. With cfg_flow_en=0, cts is ignored and rts stays 1.
- R11: A flush pulse returns both sides to idle on the next clock. txd goes to the stop level, and busy, rx_full, tx_done, frame_err and par_err all clear.
- R12: busy is 1 while the transmitter is waiting or sending, or while the receiver is inside a frame, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at OSR times the bit rate |
| cfg_nine | input | 1 | 1 selects nine-bit frames |
| cfg_par_en | input | 1 | 1 puts parity in the ninth slot |
| cfg_par_even | input | 1 | 0 odd parity, 1 even parity |
| cfg_two_stop | input | 1 | 0 one stop bit, 1 two stop bits |
| cfg_start_lvl | input | 1 | Line level of the start bit |
| cfg_stop_lvl | input | 1 | Line level of stop bits and idle |
| cfg_flow_en | input | 1 | Enables the rts/cts handshake |
| flush | input | 1 | Abort pulse for both sides |
| tx_wr | input | 1 | Write strobe for a byte to send |
| tx_data | input | DATA_W | Byte to send |
| tx_bit8 | input | 1 | Ninth data bit to send when parity is off |
| rx_rd | input | 1 | Read strobe, clears rx_full |
| rx_data | output | DATA_W | Last received byte |
| rx_bit8 | output | 1 | Last received ninth slot |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| cts | input | 1 | Partner ready to accept (1 = ready) |
| rts | output | 1 | This side ready to accept (1 = ready) |
| rx_full | output | 1 | Unread byte held |
| tx_done | output | 1 | Last frame fully sent |
| busy | output | 1 | Either side active |
| frame_err | output | 1 | Bad stop bit in last received frame |
| par_err | output | 1 | Parity mismatch in last received frame |

## Verification
The main path is driven in loopback by a table of six configurations. These cover plain eight-bit, nine-bit data, odd parity with two stop bits, even parity in nine-bit mode, and two inverted-level frames. Each transmitted frame is decoded bit by bit at mid-bit by the bench's own receiver, so an error in bit order, slot content, parity sense or stop count shows up as a mismatched bit position rather than only as a wrong byte. Hand-built frames then reach the receiver with a short start glitch, a bad stop bit and a wrong parity bit, which separates start rejection from framing and parity detection. Directed runs exercise a write while the transmitter is active, a handshake stall, and a flush in mid-frame.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;

  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SEND} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

  typedef struct packed {
    logic nine;
    logic par_en;
    logic par_even;
    logic two_stop;
    logic start_lvl;
    logic stop_lvl;
    logic flow_en;
  } uart_cfg_t;

  // ninth slot exists for nine-bit data or for parity
  function automatic logic has_slot(input uart_cfg_t c);
    return c.nine | c.par_en;
  endfunction

  // ones_odd is the xor of the data bits
  function automatic logic parity_bit(input logic ones_odd, input logic even);
    return even ? ones_odd : ~ones_odd;
  endfunction

  // total bits in a frame including the start bit
  function automatic int frame_len(input uart_cfg_t c, input int dw);
    return 1 + dw + int'(has_slot(c)) + (c.two_stop ? 2 : 1);
  endfunction

endpackage

// File: rtl/uart_xcvr_tx.sv
module uart_xcvr_tx
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              flush,
  input  uart_cfg_t         cfg,
  input  logic              cts,
  input  logic              wr,
  input  logic [DATA_W-1:0] data,
  input  logic              bit9,
  output logic              txd,
  output logic              active,
  output logic              done,
  output logic              frame_end,
  output logic              waiting
);
  localparam int FW = DATA_W + 4;
  localparam int TW = $clog2(OSR);
  localparam int BW = $clog2(FW + 1);

  tx_state_e      st;
  logic [FW-1:0]  sh;
  logic [TW-1:0]  tcnt;
  logic [BW-1:0]  bcnt;
  logic [BW-1:0]  blen;
  logic           bit_end;

  function automatic logic [FW-1:0] build_frame(input uart_cfg_t c,
                                                input logic [DATA_W-1:0] d,
                                                input logic b9);
    logic [FW-1:0] f;
    f = {FW{c.stop_lvl}};
    f[0] = c.start_lvl;
    f[DATA_W:1] = d;
    if (has_slot(c))
      f[DATA_W+1] = c.par_en ? parity_bit(^d, c.par_even) : b9;
    return f;
  endfunction

  assign bit_end   = (st == TX_SEND) && tick && (tcnt == TW'(OSR - 1));
  assign frame_end = bit_end && (bcnt + BW'(1) == blen) && !flush;
  assign waiting   = (st == TX_WAIT);
  assign active    = (st != TX_IDLE);
  assign txd       = (st == TX_SEND) ? sh[0] : cfg.stop_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= TX_IDLE;
      sh   <= '0;
      tcnt <= '0;
      bcnt <= '0;
      blen <= '0;
      done <= 1'b0;
    end else if (flush) begin
      st   <= TX_IDLE;
      tcnt <= '0;
      bcnt <= '0;
      done <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: begin
          if (wr) begin
            sh   <= build_frame(cfg, data, bit9);
            blen <= BW'(frame_len(cfg, DATA_W));
            tcnt <= '0;
            bcnt <= '0;
            done <= 1'b0;
            st   <= (cfg.flow_en && !cts) ? TX_WAIT : TX_SEND;
          end
        end
        TX_WAIT: begin
          if (!cfg.flow_en || cts) st <= TX_SEND;
        end
        TX_SEND: begin
          if (tick) begin
            if (bit_end) begin
              tcnt <= '0;
              if (bcnt + BW'(1) == blen) begin
                st   <= TX_IDLE;
                done <= 1'b1;
              end else begin
                bcnt <= bcnt + BW'(1);
                sh   <= sh >> 1;
              end
            end else begin
              tcnt <= tcnt + TW'(1);
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_xcvr_rx.sv
module uart_xcvr_rx
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              flush,
  input  uart_cfg_t         cfg,
  input  logic              rxd,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              bit9,
  output logic              full,
  output logic              ferr,
  output logic              perr,
  output logic              rts,
  output logic              active,
  output logic              frame_end,
  output logic              start_reject
);
  localparam int RW   = DATA_W + 3;
  localparam int TW   = $clog2(OSR);
  localparam int IW   = $clog2(RW + 1);
  localparam int HALF = OSR / 2;

  typedef struct packed {
    logic [DATA_W-1:0] d;
    logic              b9;
    logic              fe;
    logic              pe;
  } rx_word_t;

  rx_state_e     st;
  logic [1:0]    sync;
  logic          line;
  logic [TW-1:0] tcnt;
  logic [IW-1:0] bcnt;
  logic [IW-1:0] blen;
  logic [RW-1:0] rb;
  logic [RW-1:0] rb_nx;
  logic          mid_start;
  logic          bit_mid;
  rx_word_t      word;

  function automatic rx_word_t decode(input uart_cfg_t c, input logic [RW-1:0] b);
    rx_word_t w;
    int s0;
    s0   = DATA_W + int'(has_slot(c));
    w.d  = b[DATA_W-1:0];
    w.b9 = has_slot(c) & b[DATA_W];
    w.fe = (b[s0] != c.stop_lvl) | (c.two_stop & (b[s0+1] != c.stop_lvl));
    w.pe = c.par_en & (b[DATA_W] != parity_bit(^b[DATA_W-1:0], c.par_even));
    return w;
  endfunction

  assign line         = sync[1];
  assign mid_start    = (st == RX_START) && tick && (tcnt == TW'(HALF - 1));
  assign start_reject = mid_start && (line != cfg.start_lvl) && !flush;
  assign bit_mid      = (st == RX_BITS) && tick && (tcnt == TW'(OSR - 1));
  assign frame_end    = bit_mid && (bcnt + IW'(1) == blen) && !flush;
  assign active       = (st != RX_IDLE);
  assign rts          = !(cfg.flow_en && full);

  always_comb begin
    rb_nx       = rb;
    rb_nx[bcnt] = line;
  end

  assign word = decode(cfg, rb_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= {2{1'b1}};
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      tcnt <= '0;
      bcnt <= '0;
      blen <= '0;
      rb   <= '0;
      data <= '0;
      bit9 <= 1'b0;
      full <= 1'b0;
      ferr <= 1'b0;
      perr <= 1'b0;
    end else if (flush) begin
      st   <= RX_IDLE;
      tcnt <= '0;
      bcnt <= '0;
      full <= 1'b0;
      ferr <= 1'b0;
      perr <= 1'b0;
    end else begin
      if (rd) full <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (tick && line == cfg.start_lvl) begin
            st   <= RX_START;
            tcnt <= '0;
          end
        end
        RX_START: begin
          if (mid_start) begin
            tcnt <= '0;
            bcnt <= '0;
            blen <= IW'(frame_len(cfg, DATA_W) - 1);
            st   <= (line == cfg.start_lvl) ? RX_BITS : RX_IDLE;
          end else if (tick) begin
            tcnt <= tcnt + TW'(1);
          end
        end
        RX_BITS: begin
          if (bit_mid) begin
            tcnt <= '0;
            rb   <= rb_nx;
            bcnt <= bcnt + IW'(1);
            if (frame_end) begin
              st   <= RX_IDLE;
              data <= word.d;
              bit9 <= word.b9;
              ferr <= word.fe;
              perr <= word.pe;
              full <= 1'b1;
            end
          end else if (tick) begin
            tcnt <= tcnt + TW'(1);
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              cfg_nine,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_two_stop,
  input  logic              cfg_start_lvl,
  input  logic              cfg_stop_lvl,
  input  logic              cfg_flow_en,
  input  logic              flush,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_bit8,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  input  logic              rxd,
  output logic              txd,
  input  logic              cts,
  output logic              rts,
  output logic              rx_full,
  output logic              tx_done,
  output logic              busy,
  output logic              frame_err,
  output logic              par_err
);
  uart_cfg_t cfg;
  logic tx_active, rx_active;
  logic tx_frame_end, rx_frame_end, tx_wait, rx_start_reject;

  assign cfg = '{nine: cfg_nine, par_en: cfg_par_en, par_even: cfg_par_even,
                 two_stop: cfg_two_stop, start_lvl: cfg_start_lvl,
                 stop_lvl: cfg_stop_lvl, flow_en: cfg_flow_en};

  uart_xcvr_tx #(.DATA_W(DATA_W), .OSR(OSR)) i_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .flush(flush), .cfg(cfg),
    .cts(cts), .wr(tx_wr), .data(tx_data), .bit9(tx_bit8), .txd(txd),
    .active(tx_active), .done(tx_done), .frame_end(tx_frame_end),
    .waiting(tx_wait)
  );

  uart_xcvr_rx #(.DATA_W(DATA_W), .OSR(OSR)) i_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .flush(flush), .cfg(cfg),
    .rxd(rxd), .rd(rx_rd), .data(rx_data), .bit9(rx_bit8), .full(rx_full),
    .ferr(frame_err), .perr(par_err), .rts(rts), .active(rx_active),
    .frame_end(rx_frame_end), .start_reject(rx_start_reject)
  );

  assign busy = tx_active | rx_active;

endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic flush,
  input logic rx_rd,
  input logic cts,
  input logic cfg_flow_en,
  input logic busy,
  input logic rx_full,
  input logic tx_done,
  input logic frame_err,
  input logic par_err,
  input logic tx_frame_end,
  input logic rx_frame_end,
  input logic tx_wait,
  input logic rx_start_reject
);

  a_r11_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!busy && !rx_full && !tx_done && !frame_err && !par_err));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !rx_frame_end) |=> !rx_full);

  a_r8_full_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_frame_end));

  a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame_end |=> tx_done);

  a_r10_cts_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wait && cfg_flow_en && !cts && !flush) |=> tx_wait);

  a_r9_err_changes_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_err) |-> $past(rx_frame_end || flush));

  a_r7_reject_stores_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start_reject && !rx_full) |=> !rx_full);

  a_r12_wait_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wait |-> busy);

endmodule

bind uart_xcvr uart_xcvr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .rx_rd(rx_rd), .cts(cts),
  .cfg_flow_en(cfg_flow_en), .busy(busy), .rx_full(rx_full),
  .tx_done(tx_done), .frame_err(frame_err), .par_err(par_err),
  .tx_frame_end(tx_frame_end), .rx_frame_end(rx_frame_end),
  .tx_wait(tx_wait), .rx_start_reject(rx_start_reject)
);

// File: tb/test_uart_xcvr.sv
module test_uart_xcvr;
  localparam int DATA_W = 8;
  localparam int OSR    = 16;
  // fields: nine, par_en, par_even, two_stop, start_lvl, stop_lvl, bit8, data
  localparam logic [14:0] VECS [6] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h07},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h81},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, tick16 = 1'b0;
  logic cfg_nine = 0, cfg_par_en = 0, cfg_par_even = 0, cfg_two_stop = 0;
  logic cfg_start_lvl = 0, cfg_stop_lvl = 1, cfg_flow_en = 0;
  logic flush = 0, tx_wr = 0, tx_bit8 = 0, rx_rd = 0, cts = 0;
  logic [DATA_W-1:0] tx_data = '0, rx_data;
  logic rx_bit8, rxd, txd, rts, rx_full, tx_done, busy, frame_err, par_err;
  logic loop = 1'b1, rxd_drv = 1'b1;
  logic [1:0] tdiv = '0;
  int checks = 0, fails = 0;
  bit finished = 0;

  assign rxd = loop ? txd : rxd_drv;

  always @(negedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  uart_xcvr #(.DATA_W(DATA_W), .OSR(OSR)) i_uart_xcvr (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg_nine(cfg_nine),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_two_stop(cfg_two_stop), .cfg_start_lvl(cfg_start_lvl),
    .cfg_stop_lvl(cfg_stop_lvl), .cfg_flow_en(cfg_flow_en), .flush(flush),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_bit8(tx_bit8), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rxd(rxd), .txd(txd), .cts(cts),
    .rts(rts), .rx_full(rx_full), .tx_done(tx_done), .busy(busy),
    .frame_err(frame_err), .par_err(par_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (tick16 !== 1'b1) @(posedge clk);
    end
    #1;
  endtask

  task automatic set_cfg(input logic [14:0] v);
    {cfg_nine, cfg_par_en, cfg_par_even, cfg_two_stop, cfg_start_lvl, cfg_stop_lvl} = v[14:9];
    tx_bit8 = v[8];
    tx_data = v[7:0];
  endtask

  // bench-side frame model: bit list and length
  task automatic model(input logic [14:0] v, output logic [15:0] b, output int n, output logic b9);
    logic p;
    int ones;
    b = '0;
    n = 0;
    ones = $countones(v[7:0]);
    p = v[12] ? logic'(ones % 2) : logic'((ones % 2) == 0);
    b[n] = v[10]; n++;
    for (int i = 0; i < 8; i++) begin b[n] = v[i]; n++; end
    b9 = 1'b0;
    if (v[14] || v[13]) begin
      b9 = v[13] ? p : v[8];
      b[n] = b9; n++;
    end
    b[n] = v[9]; n++;
    if (v[11]) begin b[n] = v[9]; n++; end
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic capture(input logic sl, input int n, output logic [15:0] got);
    int guard = 0;
    got = '0;
    while (txd !== sl && guard < 20000) begin @(posedge clk); #1; guard++; end
    wait_ticks(OSR / 2);
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      wait_ticks(OSR);
      got[i] = txd;
    end
  endtask

  task automatic drive_frame(input logic [15:0] b, input int n, input logic idle);
    for (int i = 0; i < n; i++) begin
      rxd_drv = b[i];
      wait_ticks(OSR);
    end
    rxd_drv = idle;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] eb, gb;
    int n;
    logic e9;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // reset state
    check("R1 idle txd", txd, 1);
    check("R12 reset busy", busy, 0);
    check("R8 reset rx_full", rx_full, 0);
    check("R6 reset tx_done", tx_done, 0);
    check("R10 reset rts", rts, 1);

    // vector table, loopback, cts=0 with flow off (ignored)
    for (int k = 0; k < 6; k++) begin
      set_cfg(VECS[k]);
      wait_ticks(20);
      model(VECS[k], eb, n, e9);
      pulse_wr(VECS[k][7:0]);
      capture(VECS[k][10], n, gb);
      check($sformatf("R1 R2 R3 R4 R5 frame bits vec%0d", k), gb, eb);
      wait_ticks(12);
      check($sformatf("R6 tx_done vec%0d", k), tx_done, 1);
      check($sformatf("R8 rx_full vec%0d", k), rx_full, 1);
      check($sformatf("R8 rx_data vec%0d", k), rx_data, VECS[k][7:0]);
      check($sformatf("R2 rx_bit8 vec%0d", k), rx_bit8, e9);
      check($sformatf("R9 errs clean vec%0d", k), {frame_err, par_err}, 0);
      check($sformatf("R12 idle vec%0d", k), busy, 0);
      pulse_rd();
      #1;
      check($sformatf("R8 rd clears vec%0d", k), rx_full, 0);
    end

    // start glitch rejection and valid reception from driven line
    set_cfg({6'b000001, 1'b0, 8'h00});
    loop = 1'b0;
    rxd_drv = 1'b1;
    wait_ticks(20);
    rxd_drv = 1'b0;
    wait_ticks(3);
    check("R12 busy in start", busy, 1);
    rxd_drv = 1'b1;
    wait_ticks(14);
    check("R7 glitch no byte", rx_full, 0);
    check("R7 glitch idle", busy, 0);
    model({6'b000001, 1'b0, 8'h5A}, eb, n, e9);
    drive_frame(eb, n, 1'b1);
    wait_ticks(2);
    check("R7 mid-bit rx_full", rx_full, 1);
    check("R7 mid-bit rx_data", rx_data, 8'h5A);
    pulse_rd();

    // bad stop bit
    model({6'b000001, 1'b0, 8'hC3}, eb, n, e9);
    eb[n-1] = 1'b0;
    drive_frame(eb, n, 1'b1);
    wait_ticks(12);
    check("R9 frame_err", frame_err, 1);
    check("R9 no par_err", par_err, 0);
    check("R7 no false frame", rx_data, 8'hC3);
    pulse_rd();

    // wrong parity (odd, data 0x03 needs parity 1)
    set_cfg({6'b010001, 1'b0, 8'h00});
    wait_ticks(4);
    model({6'b010001, 1'b0, 8'h03}, eb, n, e9);
    check("R3 odd parity model", e9, 1);
    eb[9] = 1'b0;
    drive_frame(eb, n, 1'b1);
    wait_ticks(4);
    check("R9 par_err", par_err, 1);
    check("R9 frame_err cleared", frame_err, 0);
    pulse_rd();

    // two stop bits, second one bad
    set_cfg({6'b000101, 1'b0, 8'h00});
    wait_ticks(4);
    model({6'b000101, 1'b0, 8'h66}, eb, n, e9);
    eb[n-1] = 1'b0;
    drive_frame(eb, n, 1'b1);
    wait_ticks(12);
    check("R4 second stop checked", frame_err, 1);
    pulse_rd();

    // write while active is ignored
    loop = 1'b1;
    set_cfg({6'b000001, 1'b0, 8'h00});
    wait_ticks(20);
    check("R6 tx_done before write", tx_done, 1);
    model({6'b000001, 1'b0, 8'h11}, eb, n, e9);
    pulse_wr(8'h11);
    #1;
    check("R6 tx_done cleared by write", tx_done, 0);
    fork
      capture(1'b0, n, gb);
      begin wait_ticks(20); pulse_wr(8'hEE); end
    join
    check("R6 second write ignored", gb, eb);
    wait_ticks(40);
    check("R6 no extra frame", busy, 0);
    check("R6 rx got first byte", rx_data, 8'h11);
    pulse_rd();

    // flow control
    cfg_flow_en = 1'b1;
    cts = 1'b0;
    pulse_wr(8'h42);
    wait_ticks(30);
    check("R10 stalled txd", txd, 1);
    check("R10 stalled busy", busy, 1);
    model({6'b000001, 1'b0, 8'h42}, eb, n, e9);
    @(negedge clk); cts = 1'b1;
    capture(1'b0, n, gb);
    check("R10 frame after cts", gb, eb);
    wait_ticks(12);
    check("R10 rts low when full", rts, 0);
    cfg_flow_en = 1'b0;
    #1;
    check("R10 rts high flow off", rts, 1);
    cfg_flow_en = 1'b1;
    pulse_rd();
    #1;
    check("R10 rts high after read", rts, 1);
    cfg_flow_en = 1'b0;
    cts = 1'b0;

    // flush mid-frame
    pulse_wr(8'h77);
    wait_ticks(200);
    check("R8 byte before flush", rx_full, 1);
    pulse_wr(8'h99);
    wait_ticks(40);
    check("R12 busy mid-frame", busy, 1);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    check("R11 busy cleared", busy, 0);
    check("R11 txd stop level", txd, 1);
    check("R11 rx_full cleared", rx_full, 0);
    check("R11 tx_done cleared", tx_done, 0);
    wait_ticks(60);
    check("R11 stays idle", {busy, rx_full, txd}, 3'b001);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule